// File: doc/BRIEF.md
# Key-Protected Independent Watchdog Timer

This block is a watchdog that counts on its own slow clock, apart from the bus clock. If the main clock stops, the countdown still expires. Software drives it through four word registers on the bus clock: a command (key) register, a prescaler register, a reload register and a status register.

Three 16-bit key values control the watchdog. One starts it, one unlocks the two configuration registers, and one refreshes the countdown. Once the watchdog is running, nothing stops it except a system reset. A strap input can also start it straight out of reset.

Configuration values and key commands reach the slow domain through toggle handshakes. The status register shows, per register, that a written value has not yet been taken over. When the 12-bit down-counter runs out, the block drives a reset pulse one slow-clock cycle wide. A debug input can freeze the countdown while the processor is halted.

Top module: `kwdt_top`

## Requirements
- R1: After reset the prescaler register (address 1) reads 0, the reload register (address 2) reads 0xFFF, the status register (address 3) reads 0, and `wdt_rst` is low.
- R2: Writes to the prescaler (address 1, bits 2:0) and reload (address 2, bits 11:0) registers take effect only after key 0x5555 has been written to address 0. Before that they are ignored and the read-back value is unchanged.
- R3: Any key value other than 0x5555, 0xAAAA and 0xCCCC re-locks the configuration registers, so later prescaler or reload writes are ignored.
- R4: Status bit 0 is set from the cycle after an accepted prescaler write, and status bit 1 from the cycle after an accepted reload write. Each bit clears once the slow domain has taken the value over. A write to a register whose busy bit is set is ignored.
- R5: The counter does not run and no pulse is issued until the watchdog is started. It starts either by key 0xCCCC or by `hw_start` being high at the first slow-clock edge after reset.
- R6: Key 0xAAAA loads the counter from the reload value and selects the divider from the prescaler value. The divider is 4 << code for codes 0 to 5, and 256 for codes 6 and 7. A started watchdog then issues its pulse (reload+1)*divider slow cycles after the refresh reaches the slow domain, plus a crossing delay of a few slow cycles.
- R7: Each pulse is one slow cycle wide. After a pulse the counter reloads, and pulses repeat exactly every (reload+1)*divider slow cycles.
- R8: Refreshing more often than the timeout prevents any pulse.
- R9: Once started, no key write stops the countdown.
- R10: While `dbg_freeze` is high the countdown holds. After it falls, the countdown continues from where it stopped.
- R11: A new reload or prescaler value never alters a countdown already in progress. It is used from the next refresh or the next reload after a pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low system reset, both domains |
| slow_clk | input | 1 | Independent slow clock for the countdown |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 key, 1 prescaler, 2 reload, 3 status |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address, same map |
| rd_data | output | 16 | Read data, combinational from the addressed register |
| hw_start | input | 1 | Strap: start the watchdog straight out of reset |
| dbg_freeze | input | 1 | Hold the countdown while the core is halted |
| wdt_rst | output | 1 | Timeout pulse, one slow-clock cycle, slow-clock domain |

## Verification
The properties take for granted the following about the inputs:
- `wr_en` and `wr_addr` change only with the bus clock.
- `hw_start` stays constant around reset.
- One reset releases both domains together.
- The slow clock is slower than the bus clock, so each timeout spans several slow cycles.

The stimulus meets these conditions. It drives every bus input on the falling bus-clock edge. It changes `dbg_freeze` only on falling slow-clock edges. It sets the strap before asserting reset. The timing checks allow a window of a few slow cycles for the clock crossing, and only the spacing between two pulses is held to an exact count.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
    localparam int KEY_W  = 16;
    localparam int CNT_W  = 12;
    localparam int PR_W   = 3;
    localparam int PCNT_W = 8;

    localparam logic [KEY_W-1:0] KEY_UNLOCK  = 16'h5555;
    localparam logic [KEY_W-1:0] KEY_REFRESH = 16'hAAAA;
    localparam logic [KEY_W-1:0] KEY_START   = 16'hCCCC;

    localparam logic [1:0] ADDR_KEY  = 2'd0;
    localparam logic [1:0] ADDR_PR   = 2'd1;
    localparam logic [1:0] ADDR_RL   = 2'd2;
    localparam logic [1:0] ADDR_STAT = 2'd3;

    localparam logic [CNT_W-1:0] CNT_INIT = '1;

    typedef struct packed {
        logic             unlock;
        logic             start_t;
        logic             rfr_t;
        logic             pr_t;
        logic             rl_t;
        logic [PR_W-1:0]  pr;
        logic [CNT_W-1:0] rl;
    } bus_st_t;

    typedef struct packed {
        logic              strap_done;
        logic              started;
        logic              start_seen;
        logic              rfr_seen;
        logic              pr_seen;
        logic              rl_seen;
        logic [PR_W-1:0]   pr_cfg;
        logic [PR_W-1:0]   div;
        logic [CNT_W-1:0]  rl_cfg;
        logic [CNT_W-1:0]  cnt;
        logic [PCNT_W-1:0] pcnt;
        logic              fire;
    } core_st_t;

    // Terminal value of the prescale counter: divider minus one, capped at 256.
    function automatic logic [PCNT_W-1:0] div_limit(input logic [PR_W-1:0] code);
        int unsigned       sh;
        logic [PCNT_W:0]   v;
        sh = (code > PR_W'(6)) ? 8 : (int'(code) + 2);
        v  = (PCNT_W+1)'(1) << sh;
        v  = v - (PCNT_W+1)'(1);
        return v[PCNT_W-1:0];
    endfunction
endpackage

// File: rtl/kwdt_sync.sv
module kwdt_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg_q[s] <= '0;
                    else        stg_q[s] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg_q[s] <= '0;
                    else        stg_q[s] <= stg_q[s-1];
                end
            end
        end
    endgenerate

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/kwdt_bus.sv
module kwdt_bus
    import kwdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [KEY_W-1:0] wr_data,
    input  logic             pr_ack,
    input  logic             rl_ack,
    output logic [PR_W-1:0]  pr_val,
    output logic [CNT_W-1:0] rl_val,
    output logic             start_t,
    output logic             rfr_t,
    output logic             pr_t,
    output logic             rl_t,
    output logic             pr_busy,
    output logic             rl_busy
);
    bus_st_t st_d, st_q;

    // A request is outstanding while its toggle differs from the returned ack.
    assign pr_busy = st_q.pr_t ^ pr_ack;
    assign rl_busy = st_q.rl_t ^ rl_ack;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (wr_addr)
                ADDR_KEY: begin
                    case (wr_data)
                        KEY_UNLOCK:  st_d.unlock  = 1'b1;
                        KEY_REFRESH: st_d.rfr_t   = ~st_q.rfr_t;
                        KEY_START:   st_d.start_t = ~st_q.start_t;
                        default:     st_d.unlock  = 1'b0;
                    endcase
                end
                ADDR_PR: begin
                    if (st_q.unlock && !pr_busy) begin
                        st_d.pr   = wr_data[PR_W-1:0];
                        st_d.pr_t = ~st_q.pr_t;
                    end
                end
                ADDR_RL: begin
                    if (st_q.unlock && !rl_busy) begin
                        st_d.rl   = wr_data[CNT_W-1:0];
                        st_d.rl_t = ~st_q.rl_t;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.rl <= CNT_INIT;
        end else begin
            st_q <= st_d;
        end
    end

    assign pr_val  = st_q.pr;
    assign rl_val  = st_q.rl;
    assign start_t = st_q.start_t;
    assign rfr_t   = st_q.rfr_t;
    assign pr_t    = st_q.pr_t;
    assign rl_t    = st_q.rl_t;
endmodule

// File: rtl/kwdt_core.sv
module kwdt_core
    import kwdt_pkg::*;
(
    input  logic             slow_clk,
    input  logic             rst_n,
    input  logic             hw_start,
    input  logic             frz_s,
    input  logic             start_s,
    input  logic             rfr_s,
    input  logic             pr_s,
    input  logic             rl_s,
    input  logic [PR_W-1:0]  pr_bus,
    input  logic [CNT_W-1:0] rl_bus,
    output logic             pr_ack,
    output logic             rl_ack,
    output logic             wdt_rst
);
    core_st_t st_d, st_q;
    logic start_edge, rfr_edge, pr_edge, rl_edge, running;

    always_comb begin
        st_d       = st_q;
        st_d.fire  = 1'b0;
        start_edge = start_s ^ st_q.start_seen;
        rfr_edge   = rfr_s ^ st_q.rfr_seen;
        pr_edge    = pr_s ^ st_q.pr_seen;
        rl_edge    = rl_s ^ st_q.rl_seen;
        st_d.start_seen = start_s;
        st_d.rfr_seen   = rfr_s;
        st_d.pr_seen    = pr_s;
        st_d.rl_seen    = rl_s;

        // Strap is looked at once, on the first slow edge out of reset.
        if (!st_q.strap_done) begin
            st_d.strap_done = 1'b1;
            if (hw_start) st_d.started = 1'b1;
        end
        if (start_edge) st_d.started = 1'b1;

        // Bus values are quiet here: the bus side blocks writes while busy.
        if (pr_edge) st_d.pr_cfg = pr_bus;
        if (rl_edge) st_d.rl_cfg = rl_bus;

        running = st_q.started && !frz_s;

        if (rfr_edge) begin
            st_d.cnt  = st_d.rl_cfg;
            st_d.div  = st_d.pr_cfg;
            st_d.pcnt = '0;
        end else if (running) begin
            if (st_q.pcnt == div_limit(st_q.div)) begin
                st_d.pcnt = '0;
                if (st_q.cnt == '0) begin
                    st_d.fire = 1'b1;
                    st_d.cnt  = st_d.rl_cfg;
                    st_d.div  = st_d.pr_cfg;
                end else begin
                    st_d.cnt = st_q.cnt - CNT_W'(1);
                end
            end else begin
                st_d.pcnt = st_q.pcnt + PCNT_W'(1);
            end
        end
    end

    always_ff @(posedge slow_clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.rl_cfg <= CNT_INIT;
            st_q.cnt    <= CNT_INIT;
        end else begin
            st_q <= st_d;
        end
    end

    assign pr_ack  = st_q.pr_seen;
    assign rl_ack  = st_q.rl_seen;
    assign wdt_rst = st_q.fire;
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
    import kwdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slow_clk,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [KEY_W-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    output logic [KEY_W-1:0] rd_data,
    input  logic             hw_start,
    input  logic             dbg_freeze,
    output logic             wdt_rst
);
    logic [PR_W-1:0]  pr_val;
    logic [CNT_W-1:0] rl_val;
    logic start_t, rfr_t, pr_t, rl_t, pr_busy, rl_busy;
    logic pr_ack, rl_ack, pr_ack_s, rl_ack_s;
    logic frz_s, start_s, rfr_s, pr_s, rl_s;

    kwdt_bus u_bus (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pr_ack(pr_ack_s), .rl_ack(rl_ack_s), .pr_val(pr_val), .rl_val(rl_val),
        .start_t(start_t), .rfr_t(rfr_t), .pr_t(pr_t), .rl_t(rl_t),
        .pr_busy(pr_busy), .rl_busy(rl_busy)
    );

    kwdt_sync #(.W(5), .STAGES(2)) u_to_slow (
        .clk(slow_clk), .rst_n(rst_n),
        .din({dbg_freeze, start_t, rfr_t, pr_t, rl_t}),
        .dout({frz_s, start_s, rfr_s, pr_s, rl_s})
    );

    kwdt_sync #(.W(2), .STAGES(2)) u_to_bus (
        .clk(clk), .rst_n(rst_n),
        .din({pr_ack, rl_ack}),
        .dout({pr_ack_s, rl_ack_s})
    );

    kwdt_core u_core (
        .slow_clk(slow_clk), .rst_n(rst_n), .hw_start(hw_start), .frz_s(frz_s),
        .start_s(start_s), .rfr_s(rfr_s), .pr_s(pr_s), .rl_s(rl_s),
        .pr_bus(pr_val), .rl_bus(rl_val), .pr_ack(pr_ack), .rl_ack(rl_ack),
        .wdt_rst(wdt_rst)
    );

    always_comb begin
        case (rd_addr)
            ADDR_PR:   rd_data = {{(KEY_W-PR_W){1'b0}}, pr_val};
            ADDR_RL:   rd_data = {{(KEY_W-CNT_W){1'b0}}, rl_val};
            ADDR_STAT: rd_data = {{(KEY_W-2){1'b0}}, rl_busy, pr_busy};
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/kwdt_checker.sv
module kwdt_checker
    import kwdt_pkg::*;
(
    input logic             clk,
    input logic             slow_clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       wr_addr,
    input logic             wdt_rst,
    input logic [PR_W-1:0]  pr_val,
    input logic [CNT_W-1:0] rl_val,
    input logic             pr_busy,
    input logic             rl_busy,
    input logic             pr_req,
    input logic             rl_req
);
    p_pulse_one_cycle_r7: assert property (@(posedge slow_clk) disable iff (!rst_n)
        wdt_rst |=> !wdt_rst);

    p_pr_only_by_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pr_val) |-> $past(wr_en && (wr_addr == ADDR_PR)));

    p_rl_only_by_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rl_val) |-> $past(wr_en && (wr_addr == ADDR_RL)));

    p_rl_held_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rl_busy |=> $stable(rl_val));

    p_pr_held_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pr_busy |=> $stable(pr_val));

    p_req_held_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pr_busy && rl_busy) |=> ($stable(pr_req) && $stable(rl_req)));
endmodule

bind kwdt_top kwdt_checker u_chk (
    .clk(clk), .slow_clk(slow_clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wdt_rst(wdt_rst), .pr_val(pr_val), .rl_val(rl_val), .pr_busy(pr_busy),
    .rl_busy(rl_busy), .pr_req(pr_t), .rl_req(rl_t)
);

// File: tb/kwdt_top_tb.sv
module kwdt_top_tb;
    localparam logic [1:0] A_KEY = 2'd0, A_PR = 2'd1, A_RL = 2'd2, A_ST = 2'd3;

    logic        clk = 1'b0, slow_clk = 1'b0, rst_n = 1'b0;
    logic        wr_en = 1'b0, hw_start = 1'b0, dbg_freeze = 1'b0;
    logic [1:0]  wr_addr = 2'd0, rd_addr = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic [15:0] rd_data;
    logic        wdt_rst;

    always #4 clk = ~clk;
    always #40 slow_clk = ~slow_clk;

    kwdt_top u_dut (
        .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .hw_start(hw_start),
        .dbg_freeze(dbg_freeze), .wdt_rst(wdt_rst)
    );

    int n_cmp = 0, n_bad = 0;
    int lcyc = 0, pulses = 0, last_at = 0, prev_at = 0;
    bit done = 1'b0;

    always @(posedge slow_clk) begin
        lcyc = lcyc + 1;
        if (wdt_rst) begin
            pulses  = pulses + 1;
            prev_at = last_at;
            last_at = lcyc;
        end
    end

    function automatic int period(input int code, input int rl);
        int c;
        c = (code > 6) ? 6 : code;
        return (rl + 1) * (4 << c);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        @(negedge clk);
        rd_addr = a;
        #1;
        v = int'(rd_data);
    endtask

    task automatic wait_idle();
        int v;
        for (int i = 0; i < 300; i++) begin
            rd(A_ST, v);
            if (v == 0) break;
        end
    endtask

    task automatic do_reset(input bit hs);
        hw_start = hs;
        rst_n = 1'b0;
        repeat (3) @(negedge slow_clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Freeze, program divider code and reload, refresh, leave frozen.
    task automatic arm(input int code, input int rl);
        @(negedge slow_clk);
        dbg_freeze = 1'b1;
        repeat (5) @(negedge slow_clk);
        wr(A_KEY, 16'h5555);
        wr(A_PR, 16'(code));
        wr(A_RL, 16'(rl));
        wait_idle();
        wr(A_KEY, 16'hAAAA);
        repeat (5) @(negedge slow_clk);
    endtask

    task automatic wait_pulse(input int maxc, output bit got);
        int p0;
        p0 = pulses;
        got = 1'b0;
        for (int i = 0; i < maxc; i++) begin
            @(negedge slow_clk);
            if (pulses != p0) begin
                got = 1'b1;
                break;
            end
        end
    endtask

    task automatic release_time(input int t, input string req);
        int w;
        bit got;
        @(negedge slow_clk);
        w = lcyc;
        dbg_freeze = 1'b0;
        wait_pulse(t + 50, got);
        chk(got && (last_at - w >= t + 1) && (last_at - w <= t + 5), req,
            got ? last_at - w : -1, t + 3);
    endtask

    task automatic spacing(input int t, input string req);
        bit got;
        wait_pulse(t + 50, got);
        chk(got && (last_at - prev_at == t), req, got ? last_at - prev_at : -1, t);
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
        finish_run();
    end

    initial begin
        int v, w, p, code, rl;
        bit got;
        void'($urandom(32'd4242));

        do_reset(1'b0);
        // R1 reset state
        rd(A_PR, v);  chk(v == 0, "R1 prescaler", v, 0);
        rd(A_RL, v);  chk(v == 16'hFFF, "R1 reload", v, 16'hFFF);
        rd(A_ST, v);  chk(v == 0, "R1 status", v, 0);
        chk(wdt_rst == 1'b0 && pulses == 0, "R1 reset out", pulses, 0);

        // R2 locked writes ignored
        wr(A_PR, 16'd5);     rd(A_PR, v); chk(v == 0, "R2 locked prescaler", v, 0);
        wr(A_RL, 16'h010);   rd(A_RL, v); chk(v == 16'hFFF, "R2 locked reload", v, 16'hFFF);

        // R2 unlock, R4 busy flag
        wr(A_KEY, 16'h5555);
        wr(A_PR, 16'd3);
        rd(A_ST, v); chk(v == 1, "R4 prescaler busy", v, 1);
        wait_idle();
        rd(A_ST, v); chk(v == 0, "R4 busy clears", v, 0);
        rd(A_PR, v); chk(v == 3, "R2 unlocked prescaler", v, 3);

        // R4 second write while busy is dropped
        wr(A_RL, 16'd5);
        wr(A_RL, 16'd9);
        rd(A_ST, v); chk(v == 2, "R4 reload busy", v, 2);
        wait_idle();
        rd(A_RL, v); chk(v == 5, "R4 write during busy ignored", v, 5);

        // R3 stray key re-locks
        wr(A_KEY, 16'h1234);
        wr(A_PR, 16'd6);
        wait_idle();
        rd(A_PR, v); chk(v == 3, "R3 relock", v, 3);

        // R5 not started: no pulse
        arm(0, 1);
        p = pulses;
        @(negedge slow_clk);
        dbg_freeze = 1'b0;
        repeat (200) @(negedge slow_clk);
        chk(pulses == p, "R5 idle before start", pulses - p, 0);

        // R5 start key
        @(negedge slow_clk);
        w = lcyc;
        wr(A_KEY, 16'hCCCC);
        wait_pulse(100, got);
        chk(got && (last_at - w >= 9) && (last_at - w <= 15), "R5 start key",
            got ? last_at - w : -1, 12);

        // R7 periodic, R9 keys do not stop it
        spacing(period(0, 1), "R7 repeat period");
        wr(A_KEY, 16'h0000);
        wr(A_KEY, 16'hFFFF);
        wr(A_KEY, 16'h5555);
        wr(A_KEY, 16'hABCD);
        spacing(period(0, 1), "R9 still running");

        // R6 shortest timeout
        arm(0, 0);
        release_time(period(0, 0), "R6 minimum timeout");
        spacing(period(0, 0), "R7 minimum spacing");

        // R10 freeze
        arm(0, 2);
        p = pulses;
        repeat (300) @(negedge slow_clk);
        chk(pulses == p, "R10 frozen", pulses - p, 0);
        release_time(period(0, 2), "R10 resume");

        // R8 refresh keeps it quiet
        arm(0, 7);
        p = pulses;
        @(negedge slow_clk);
        dbg_freeze = 1'b0;
        for (int i = 0; i < 12; i++) begin
            repeat (12) @(negedge slow_clk);
            wr(A_KEY, 16'hAAAA);
        end
        chk(pulses == p, "R8 refreshed", pulses - p, 0);

        // R11 new reload waits for the next reload
        arm(0, 3);
        release_time(period(0, 3), "R6 reload 3");
        wr(A_KEY, 16'h5555);
        wr(A_RL, 16'd7);
        spacing(period(0, 3), "R11 old count kept");
        spacing(period(0, 7), "R11 new count used");

        // R6 codes 6 and 7 both divide by 256
        arm(6, 1);
        release_time(512, "R6 code 6");
        arm(7, 1);
        release_time(512, "R6 code 7");

        // R6 R7 random settings
        for (int i = 0; i < 8; i++) begin
            code = int'($urandom % 8);
            rl   = (code > 4) ? 0 : int'($urandom % 4);
            arm(code, rl);
            release_time(period(code, rl), "R6 random");
            spacing(period(code, rl), "R7 random");
        end

        // R5 strap start
        do_reset(1'b1);
        rd(A_ST, v); chk(v == 0, "R1 status after reset", v, 0);
        arm(0, 2);
        release_time(period(0, 2), "R5 hw start");

        finish_run();
    end
endmodule